// File: doc/BRIEF.md
# Accumulator and Carry Register Operations Unit

This unit carries out the register-class instructions of a 16-bit accumulator machine. The sequencer raises the execute strobe in the step where such an instruction runs, and presents the instruction word, the current accumulator and the current carry bit on the inputs. On the next clock edge the unit presents the new accumulator and carry values. In the same cycle it raises a one-cycle done pulse, which tells the sequencer to reset its step counter. It also raises a skip pulse when the sequencer must advance the program counter one extra time, and a halt pulse when the run flag must be cleared.

Bits 15:12 of the instruction select the class. A register instruction carries `0111` there, which means opcode 7 with the indirect bit clear. Bits 11:0 name the operation, with exactly one bit set. For the two rotate operations, the carry bit and the accumulator together form one 17-bit ring.

Top module: `accRegOpUnit`

## Requirements
- R1: An executed word 0x7800 makes the accumulator output zero and leaves the carry equal to `carryIn`.
- R2: An executed word 0x7400 makes the carry output 0 and leaves the accumulator equal to `accIn`.
- R3: 0x7200 outputs the bitwise inverse of `accIn` and keeps the carry. 0x7100 outputs the inverse of `carryIn` and keeps the accumulator.
- R4: 0x7080 rotates right through the carry. The new accumulator is `{carryIn, accIn[15:1]}` and the new carry is `accIn[0]`. Seventeen such steps restore both values.
- R5: 0x7040 rotates left through the carry. The new accumulator is `{accIn[14:0], carryIn}` and the new carry is `accIn[15]`. Seventeen such steps restore both values.
- R6: 0x7020 outputs `accIn + 1`, wrapping 0xFFFF to 0x0000, and keeps the carry.
- R7: The four skip operations assert `skipPulse` only when their condition holds, and they never change the accumulator or the carry:
  - 0x7010 skips when `accIn[15]` is 0.
  - 0x7008 skips when `accIn[15]` is 1.
  - 0x7004 skips when `accIn` is zero.
  - 0x7002 skips when `carryIn` is 0.
- R8: 0x7001 asserts `haltPulse`, never together with `skipPulse`, and leaves the accumulator and the carry unchanged.
- R9: A strobed word whose bits 15:12 are `0111` updates the outputs and raises `donePulse` on the first clock edge after the strobe. All pulses last exactly one cycle.
- R10: A strobed `0111` word is treated as a no-operation when its low 12 bits are zero or have more than one bit set:
  - the accumulator and carry outputs copy the inputs;
  - `donePulse` is asserted;
  - `skipPulse` and `haltPulse` stay low.
- R11: While the strobe is low, or while it is high with bits 15:12 other than `0111`, the outputs hold their previous values and all pulses stay low.
- R12: During reset the accumulator output is zero, the carry output is 0 and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| execStb | input | 1 | Execute strobe from the sequencer |
| instrWord | input | 16 | Instruction word |
| accIn | input | 16 | Current accumulator |
| carryIn | input | 1 | Current carry bit |
| accOut | output | 16 | Updated accumulator |
| carryOut | output | 1 | Updated carry bit |
| skipPulse | output | 1 | Request to advance the program counter once more |
| haltPulse | output | 1 | Request to clear the run flag |
| donePulse | output | 1 | Instruction complete; the step counter resets |

## Verification
The bench uses the values where a wrong design breaks visibly:
- Incrementing 0xFFFF shows a design that carries into the carry bit instead of wrapping.
- Rotating 0x8001 shows whether the carry enters at the correct end, where a swapped rotate direction would move it.
- Runs of 17 rotations in each direction catch a carry left out of the ring, which would not return to the start after 17 steps.
- Each skip is tried with its condition both true and false, so an inverted sign test shows up.
- Words with two bits set, words with no bit set, and words of the wrong class are issued. A decoder that merely tests bits would run two operations at once, or would act on memory and I/O words.

// File: rtl/accRegOpPkg.sv
package accRegOpPkg;

  // Class code in instrWord[15:12] for register instructions (opcode 7, indirect bit clear).
  localparam logic [3:0] REG_CLASS = 4'b0111;

  // Positions of the operation bits within the low field.
  localparam int SEL_HLT = 0;
  localparam int SEL_SZE = 1;
  localparam int SEL_SZA = 2;
  localparam int SEL_SNA = 3;
  localparam int SEL_SPA = 4;
  localparam int SEL_INC = 5;
  localparam int SEL_CIL = 6;
  localparam int SEL_CIR = 7;
  localparam int SEL_CME = 8;
  localparam int SEL_CMA = 9;
  localparam int SEL_CLE = 10;
  localparam int SEL_CLA = 11;
  localparam int NUM_OPS = 12;

  typedef struct packed {
    logic clrAcc;
    logic clrCarry;
    logic cmpAcc;
    logic cmpCarry;
    logic rotRight;
    logic rotLeft;
    logic incAcc;
    logic skipPos;
    logic skipNeg;
    logic skipZero;
    logic skipCarryZero;
    logic halt;
    logic done;
  } regOpStb_t;

endpackage

// File: rtl/regOpCtrl.sv
module regOpCtrl
  import accRegOpPkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int CLASS_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               execStb,
  input  logic [INSTR_W-1:0] instrWord,
  output regOpStb_t          stb
);

  localparam int SEL_W = INSTR_W - CLASS_W;

  logic [CLASS_W-1:0] classBits;
  logic [SEL_W-1:0]   selBits;
  logic               isRegOp;
  logic               singleSel;
  logic [NUM_OPS-1:0] hit;

  assign classBits = instrWord[INSTR_W-1 -: CLASS_W];
  assign selBits   = instrWord[SEL_W-1:0];
  assign isRegOp   = execStb && (classBits == REG_CLASS);
  assign singleSel = $onehot(selBits);

  // Gate each operation bit, so only an exact single-bit code selects it.
  genvar k;
  generate
    for (k = 0; k < NUM_OPS; k++) begin : g_hit
      assign hit[k] = isRegOp && singleSel && selBits[k];
    end
  endgenerate

  always_comb begin
    stb               = '0;
    stb.clrAcc        = hit[SEL_CLA];
    stb.clrCarry      = hit[SEL_CLE];
    stb.cmpAcc        = hit[SEL_CMA];
    stb.cmpCarry      = hit[SEL_CME];
    stb.rotRight      = hit[SEL_CIR];
    stb.rotLeft       = hit[SEL_CIL];
    stb.incAcc        = hit[SEL_INC];
    stb.skipPos       = hit[SEL_SPA];
    stb.skipNeg       = hit[SEL_SNA];
    stb.skipZero      = hit[SEL_SZA];
    stb.skipCarryZero = hit[SEL_SZE];
    stb.halt          = hit[SEL_HLT];
    stb.done          = isRegOp;
  end

  AST_ONE_OP_AT_A_TIME: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hit)) else $error("more than one operation strobe");                 // R10
  AST_DONE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    stb.done |-> (execStb && instrWord[INSTR_W-1 -: CLASS_W] == REG_CLASS))
    else $error("done without strobe");                                           // R9
  AST_OP_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (|hit) |-> stb.done) else $error("operation without done");                    // R11

endmodule

// File: rtl/regOpData.sv
module regOpData
  import accRegOpPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  regOpStb_t         stb,
  input  logic [DATA_W-1:0] accIn,
  input  logic              carryIn,
  output logic [DATA_W-1:0] accOut,
  output logic              carryOut,
  output logic              skipPulse,
  output logic              haltPulse,
  output logic              donePulse
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] nextAcc;
  logic              nextCarry;
  logic              skipCond;

  always_comb begin
    nextAcc   = accIn;
    nextCarry = carryIn;
    if (stb.clrAcc)   nextAcc   = '0;
    if (stb.clrCarry) nextCarry = 1'b0;
    if (stb.cmpAcc)   nextAcc   = ~accIn;
    if (stb.cmpCarry) nextCarry = ~carryIn;
    if (stb.rotRight) begin
      nextAcc   = {carryIn, accIn[MSB:1]};
      nextCarry = accIn[0];
    end
    if (stb.rotLeft) begin
      nextAcc   = {accIn[MSB-1:0], carryIn};
      nextCarry = accIn[MSB];
    end
    if (stb.incAcc)   nextAcc   = accIn + 1'b1;
  end

  assign skipCond = (stb.skipPos       && !accIn[MSB])
                 || (stb.skipNeg       &&  accIn[MSB])
                 || (stb.skipZero      && (accIn == '0))
                 || (stb.skipCarryZero && !carryIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accOut    <= '0;
      carryOut  <= 1'b0;
      skipPulse <= 1'b0;
      haltPulse <= 1'b0;
      donePulse <= 1'b0;
    end else begin
      if (stb.done) begin
        accOut   <= nextAcc;
        carryOut <= nextCarry;
      end
      skipPulse <= skipCond;
      haltPulse <= stb.halt;
      donePulse <= stb.done;
    end
  end

  AST_CLEAR_ACC: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrAcc |=> (accOut == '0 && carryOut == $past(carryIn)))
    else $error("clear acc");                                                     // R1
  AST_CLEAR_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrCarry |=> (!carryOut && accOut == $past(accIn)))
    else $error("clear carry");                                                   // R2
  AST_INVERT_ACC: assert property (@(posedge clk) disable iff (!rstN)
    stb.cmpAcc |=> (accOut == ~$past(accIn))) else $error("invert acc");         // R3
  AST_ROTATE_RIGHT: assert property (@(posedge clk) disable iff (!rstN)
    stb.rotRight |=> ({accOut, carryOut} == {$past(carryIn), $past(accIn)}))
    else $error("rotate right");                                                  // R4
  AST_ROTATE_LEFT: assert property (@(posedge clk) disable iff (!rstN)
    stb.rotLeft |=> ({carryOut, accOut} == {$past(accIn), $past(carryIn)}))
    else $error("rotate left");                                                   // R5
  AST_INCREMENT: assert property (@(posedge clk) disable iff (!rstN)
    stb.incAcc |=> (accOut == $past(accIn) + 1'b1)) else $error("increment");    // R6
  AST_SKIP_IN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    skipPulse |-> donePulse) else $error("skip without done");                    // R7
  AST_HALT_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    haltPulse |-> (donePulse && !skipPulse)) else $error("halt with skip");       // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.done |=> ($stable(accOut) && $stable(carryOut) && !donePulse))
    else $error("idle change");                                                   // R11

endmodule

// File: rtl/accRegOpUnit.sv
module accRegOpUnit
  import accRegOpPkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CLASS_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              execStb,
  input  logic [DATA_W-1:0] instrWord,
  input  logic [DATA_W-1:0] accIn,
  input  logic              carryIn,
  output logic [DATA_W-1:0] accOut,
  output logic              carryOut,
  output logic              skipPulse,
  output logic              haltPulse,
  output logic              donePulse
);

  regOpStb_t opStb;

  regOpCtrl #(.INSTR_W(DATA_W), .CLASS_W(CLASS_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .execStb   (execStb),
    .instrWord (instrWord),
    .stb       (opStb)
  );

  regOpData #(.DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (opStb),
    .accIn     (accIn),
    .carryIn   (carryIn),
    .accOut    (accOut),
    .carryOut  (carryOut),
    .skipPulse (skipPulse),
    .haltPulse (haltPulse),
    .donePulse (donePulse)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> (accOut == '0 && !carryOut && !skipPulse && !haltPulse && !donePulse))
    else $error("reset state");                                                   // R12

endmodule

// File: tb/test_accRegOpUnit.sv
`timescale 1ns/1ps
module test_accRegOpUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        execStb = 1'b0;
  logic [15:0] instrWord = '0;
  logic [15:0] accIn = '0;
  logic        carryIn = 1'b0;
  logic [15:0] accOut;
  logic        carryOut, skipPulse, haltPulse, donePulse;

  always #2.5 clk = ~clk;

  accRegOpUnit i_accRegOpUnit (
    .clk(clk), .rstN(rstN), .execStb(execStb), .instrWord(instrWord),
    .accIn(accIn), .carryIn(carryIn), .accOut(accOut), .carryOut(carryOut),
    .skipPulse(skipPulse), .haltPulse(haltPulse), .donePulse(donePulse)
  );

  typedef struct {
    logic [15:0] acc;
    logic        e;
    logic        skip;
    logic        halt;
    logic        done;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;
  logic [15:0] mAcc = '0;
  logic        mE = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Driver: computes the expected result from the requirements and queues it.
  task automatic issue(input logic [15:0] iw, input logic [15:0] a, input logic e, input bit stb, input string tag);
    expItem_t x;
    x.acc = mAcc; x.e = mE; x.skip = 0; x.halt = 0; x.done = 0; x.tag = tag;
    if (stb && iw[15:12] == 4'b0111) begin
      x.done = 1; x.acc = a; x.e = e;
      case (iw[11:0])
        12'h800: x.acc = 16'h0000;
        12'h400: x.e = 1'b0;
        12'h200: x.acc = ~a;
        12'h100: x.e = ~e;
        12'h080: begin x.acc = {e, a[15:1]}; x.e = a[0]; end
        12'h040: begin x.acc = {a[14:0], e}; x.e = a[15]; end
        12'h020: x.acc = a + 16'd1;
        12'h010: x.skip = (a[15] == 1'b0);
        12'h008: x.skip = (a[15] == 1'b1);
        12'h004: x.skip = (a == 16'h0000);
        12'h002: x.skip = (e == 1'b0);
        12'h001: x.halt = 1'b1;
        default: ;
      endcase
    end
    mAcc = x.acc; mE = x.e;
    @(negedge clk);
    instrWord = iw; accIn = a; carryIn = e; execStb = stb;
    if (stb) expQ.push_back(x);
    @(negedge clk);
    execStb = 1'b0;
    if (!stb) begin
      check(donePulse == 0 && skipPulse == 0 && haltPulse == 0, {tag, " R11 pulses"},
            {29'd0, donePulse, skipPulse, haltPulse}, 32'd0);
      check(accOut == mAcc && carryOut == mE, {tag, " R11 hold"}, {15'd0, carryOut, accOut}, {15'd0, mE, mAcc});
    end
    @(posedge clk); #1;
    check(donePulse == 0 && skipPulse == 0 && haltPulse == 0, {tag, " R9 pulse width"},
          {29'd0, donePulse, skipPulse, haltPulse}, 32'd0);
    check(accOut == mAcc && carryOut == mE, {tag, " R11 idle hold"}, {15'd0, carryOut, accOut}, {15'd0, mE, mAcc});
  endtask

  // Monitor: pops and compares each result the cycle after a strobe.
  initial begin
    forever begin
      @(posedge clk);
      if (rstN && execStb) begin
        expItem_t x;
        #1;
        if (expQ.size() == 0) begin
          check(0, "monitor queue empty R9", 0, 1);
        end else begin
          x = expQ.pop_front();
          check(accOut == x.acc && carryOut == x.e, {x.tag, " data"},
                {15'd0, carryOut, accOut}, {15'd0, x.e, x.acc});
          check(skipPulse == x.skip && haltPulse == x.halt && donePulse == x.done, {x.tag, " pulses"},
                {29'd0, donePulse, skipPulse, haltPulse}, {29'd0, x.done, x.skip, x.halt});
        end
      end
    end
  end

  initial begin
    #200000;
    check(0, "watchdog R9", 0, 1);
    finish();
  end

  initial begin
    logic [15:0] startAcc;
    logic        startE;
    repeat (3) @(negedge clk);
    check(accOut == 0 && carryOut == 0 && !skipPulse && !haltPulse && !donePulse, "R12 reset state",
          {14'd0, carryOut, skipPulse, accOut}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    issue(16'h7800, 16'h1234, 1'b1, 1, "R1 clear acc");
    issue(16'h7400, 16'hABCD, 1'b1, 1, "R2 clear carry");
    issue(16'h7200, 16'h0F0F, 1'b0, 1, "R3 invert acc");
    issue(16'h7100, 16'h5555, 1'b0, 1, "R3 invert carry");
    issue(16'h7080, 16'h8001, 1'b0, 1, "R4 rotate right");
    issue(16'h7040, 16'h8001, 1'b0, 1, "R5 rotate left");
    issue(16'h7020, 16'hFFFF, 1'b0, 1, "R6 increment wrap");
    issue(16'h7020, 16'h1234, 1'b1, 1, "R6 increment");
    issue(16'h7010, 16'h7FFF, 1'b0, 1, "R7 skip positive true");
    issue(16'h7010, 16'h8000, 1'b0, 1, "R7 skip positive false");
    issue(16'h7008, 16'h8000, 1'b1, 1, "R7 skip negative true");
    issue(16'h7008, 16'h0001, 1'b1, 1, "R7 skip negative false");
    issue(16'h7004, 16'h0000, 1'b1, 1, "R7 skip zero true");
    issue(16'h7004, 16'h0100, 1'b1, 1, "R7 skip zero false");
    issue(16'h7002, 16'h4444, 1'b0, 1, "R7 skip carry zero true");
    issue(16'h7002, 16'h4444, 1'b1, 1, "R7 skip carry zero false");
    issue(16'h7001, 16'h9999, 1'b1, 1, "R8 halt");
    issue(16'h7000, 16'h2468, 1'b1, 1, "R10 no bit set");
    issue(16'h7003, 16'h0000, 1'b0, 1, "R10 two bits set");
    issue(16'h7801, 16'h3333, 1'b1, 1, "R10 clear plus halt");
    issue(16'hF800, 16'h1111, 1'b0, 1, "R11 io class");
    issue(16'h2000, 16'h2222, 1'b0, 1, "R11 memory class");
    issue(16'h7800, 16'h5A5A, 1'b1, 0, "R11 no strobe");

    startAcc = 16'hB8F2; startE = 1'b1;
    mAcc = accOut; mE = carryOut;
    issue(16'h7080, startAcc, startE, 1, "R4 ring step");
    for (int s = 1; s < 17; s++) issue(16'h7080, accOut, carryOut, 1, "R4 ring step");
    check(accOut == startAcc && carryOut == startE, "R4 17-step round trip",
          {15'd0, carryOut, accOut}, {15'd0, startE, startAcc});

    startAcc = 16'h0053; startE = 1'b0;
    issue(16'h7040, startAcc, startE, 1, "R5 ring step");
    for (int s = 1; s < 17; s++) issue(16'h7040, accOut, carryOut, 1, "R5 ring step");
    check(accOut == startAcc && carryOut == startE, "R5 17-step round trip",
          {15'd0, carryOut, accOut}, {15'd0, startE, startAcc});

    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R9 all results seen", expQ.size(), 0);
    finish();
  end

endmodule